// File: doc/BRIEF.md
# Double-Buffered Parallel Programming Register

This block is the byte-wide programming front end for a frequency synthesizer's divider counters. A host drives an 8-bit bus and pulses one of three section strobes to fill a primary register with the main divider value (9 bits), the swallow value (4 bits) and the reference divider value (6 bits). A hop strobe copies the whole primary set into a secondary set in one step. A live select input then picks which of the two sets drives the divider outputs, so the next frequency can be loaded while the current one stays in use.

A fourth strobe loads a separate control byte. That byte reaches its output only while an active-low enable input is held low. Two mode inputs gate the whole interface: strobes act only while both are low. All strobes are asynchronous levels. Each one passes through a synchronizer in the system clock domain, and only its rising edge acts.

Top module: `dbuf_prog_reg`

## Requirements
- R1: After reset, every primary, secondary and control register is zero, so all outputs read zero.
- R2: A rising edge on the low-section strobe stores `bus_i[7:0]` as main divider bits 8'b of `[7:0]` in the primary set.
- R3: A rising edge on the high-section strobe stores `bus_i[6]` as main divider bit 8 and `bus_i[5:0]` as the reference divider. `bus_i[7]` has no effect.
- R4: A rising edge on the swallow strobe stores `bus_i[3:0]` as the swallow value. `bus_i[7:4]` have no effect.
- R5: A rising edge on the hop strobe copies the whole primary set into the secondary set. The secondary set changes at no other time.
- R6: While `use_pri_i` is 1 the divider outputs show the primary set. While it is 0 they show the secondary set. Toggling it takes effect without any strobe.
- R7: A rising edge on the control strobe stores `bus_i` as the control byte. `ctl_o` equals that byte while `ctl_en_n_i` is 0 and is all zeros while it is 1.
- R8: While `mode_a_i` or `mode_b_i` is 1, strobe edges change no register.
- R9: Each strobe acts once per rising edge. Data changed while the strobe stays high is not captured. The write is visible at the outputs no later than SYNC_STAGES+1 clock cycles after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_a_i | input | 1 | Interface mode input; must be 0 for parallel writes |
| mode_b_i | input | 1 | Interface mode input; must be 0 for parallel writes |
| bus_i | input | 8 | Data byte |
| wr_lo_i | input | 1 | Strobe for main divider low byte |
| wr_hi_i | input | 1 | Strobe for main divider bit 8 and reference divider |
| wr_sw_i | input | 1 | Strobe for swallow value |
| hop_i | input | 1 | Strobe that copies primary to secondary |
| wr_ctl_i | input | 1 | Strobe for control byte |
| use_pri_i | input | 1 | 1 selects primary set, 0 selects secondary set |
| ctl_en_n_i | input | 1 | Active-low enable for control byte output |
| m_div_o | output | 9 | Main divider value |
| a_div_o | output | 4 | Swallow value |
| r_div_o | output | 6 | Reference divider value |
| ctl_o | output | 8 | Control bits, gated by enable |

## Verification
The section writes use bytes that set the bits each section must discard. This shows that the bit mapping, not a plain byte copy, reaches the outputs. A hop is followed by a new primary load and both select settings, which separates the secondary set from the primary set. Control loads are read with the enable at both levels. Strobes issued with either mode input high, and a data change while a strobe is held high, show that only rising edges in parallel mode act.

// File: rtl/dbuf_prog_reg.sv
module dbuf_prog_reg #(
  parameter int DW          = 8,
  parameter int MW          = 9,
  parameter int AW          = 4,
  parameter int RW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_a_i,
  input  logic          mode_b_i,
  input  logic [DW-1:0] bus_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic          wr_sw_i,
  input  logic          hop_i,
  input  logic          wr_ctl_i,
  input  logic          use_pri_i,
  input  logic          ctl_en_n_i,
  output logic [MW-1:0] m_div_o,
  output logic [AW-1:0] a_div_o,
  output logic [RW-1:0] r_div_o,
  output logic [DW-1:0] ctl_o
);
  localparam int NSTB = 5;
  localparam int S_LO = 0, S_HI = 1, S_SW = 2, S_HOP = 3, S_CTL = 4;
  localparam int HW = RW + 1;

  logic              par_on;
  logic [NSTB-1:0]   stb_raw, last_q, rise;
  logic [SYNC_STAGES-1:0] sync_q [NSTB];

  logic [DW-1:0] pri_lo_q, sec_lo_q, enh_q;
  logic [HW-1:0] pri_hi_q, sec_hi_q;
  logic [AW-1:0] pri_sw_q, sec_sw_q;

  assign par_on  = ~(mode_a_i | mode_b_i);
  assign stb_raw = {wr_ctl_i, hop_i, wr_sw_i, wr_hi_i, wr_lo_i};

  for (genvar g = 0; g < NSTB; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q[g] <= '0;
        last_q[g] <= 1'b0;
      end else begin
        sync_q[g] <= {sync_q[g][SYNC_STAGES-2:0], stb_raw[g]};
        last_q[g] <= sync_q[g][SYNC_STAGES-1];
      end
    end
    assign rise[g] = par_on & sync_q[g][SYNC_STAGES-1] & ~last_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_lo_q <= '0;
      pri_hi_q <= '0;
      pri_sw_q <= '0;
      sec_lo_q <= '0;
      sec_hi_q <= '0;
      sec_sw_q <= '0;
      enh_q    <= '0;
    end else begin
      if (rise[S_LO])  pri_lo_q <= bus_i;
      if (rise[S_HI])  pri_hi_q <= bus_i[HW-1:0];
      if (rise[S_SW])  pri_sw_q <= bus_i[AW-1:0];
      if (rise[S_CTL]) enh_q    <= bus_i;
      if (rise[S_HOP]) begin
        sec_lo_q <= pri_lo_q;
        sec_hi_q <= pri_hi_q;
        sec_sw_q <= pri_sw_q;
      end
    end
  end

  assign m_div_o = use_pri_i ? {pri_hi_q[HW-1], pri_lo_q} : {sec_hi_q[HW-1], sec_lo_q};
  assign r_div_o = use_pri_i ? pri_hi_q[RW-1:0] : sec_hi_q[RW-1:0];
  assign a_div_o = use_pri_i ? pri_sw_q : sec_sw_q;
  assign ctl_o   = ctl_en_n_i ? '0 : enh_q;
endmodule

// File: rtl/dbuf_prog_reg_chk.sv
module dbuf_prog_reg_chk #(
  parameter int PW = 19,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          par_on,
  input logic          hop_rise,
  input logic [PW-1:0] pri,
  input logic [PW-1:0] sec,
  input logic [DW-1:0] enh,
  input logic          ctl_en_n_i,
  input logic [DW-1:0] ctl_o
);
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pri == '0 && sec == '0 && enh == '0));

  a_r5_hop_copy: assert property (@(posedge clk) disable iff (!rst_n)
    hop_rise |=> sec == $past(pri));

  a_r5_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hop_rise |=> $stable(sec));

  a_r8_mode_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    !par_on |=> ($stable(pri) && $stable(sec) && $stable(enh)));

  a_r7_ctl_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en_n_i |-> ctl_o == '0);

  a_r7_ctl_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en_n_i |-> ctl_o == enh);
endmodule

bind dbuf_prog_reg dbuf_prog_reg_chk #(.PW(DW + RW + 1 + AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .par_on     (par_on),
  .hop_rise   (rise[3]),
  .pri        ({pri_hi_q, pri_lo_q, pri_sw_q}),
  .sec        ({sec_hi_q, sec_lo_q, sec_sw_q}),
  .enh        (enh_q),
  .ctl_en_n_i (ctl_en_n_i),
  .ctl_o      (ctl_o)
);

// File: tb/dbuf_prog_reg_tb_top.sv
module dbuf_prog_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      req;
    logic [8:0] m;
    logic [3:0] a;
    logic [5:0] r;
    logic [7:0] c;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic mode_a_i = 0, mode_b_i = 0;
  logic [7:0] bus_i = '0;
  logic wr_lo_i = 0, wr_hi_i = 0, wr_sw_i = 0, hop_i = 0, wr_ctl_i = 0;
  logic use_pri_i = 1, ctl_en_n_i = 1;
  logic [8:0] m_div_o;
  logic [3:0] a_div_o;
  logic [5:0] r_div_o;
  logic [7:0] ctl_o;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t sb_q[$];

  logic [8:0] p_m = 0, s_m = 0;
  logic [3:0] p_a = 0, s_a = 0;
  logic [5:0] p_r = 0, s_r = 0;
  logic [7:0] e_c = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbuf_prog_reg dut_i (
    .clk(clk), .rst_n(rst_n), .mode_a_i(mode_a_i), .mode_b_i(mode_b_i),
    .bus_i(bus_i), .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .wr_sw_i(wr_sw_i),
    .hop_i(hop_i), .wr_ctl_i(wr_ctl_i), .use_pri_i(use_pri_i),
    .ctl_en_n_i(ctl_en_n_i), .m_div_o(m_div_o), .a_div_o(a_div_o),
    .r_div_o(r_div_o), .ctl_o(ctl_o)
  );

  task automatic push_exp(input string req);
    exp_t e;
    e.req = req;
    e.m = use_pri_i ? p_m : s_m;
    e.a = use_pri_i ? p_a : s_a;
    e.r = use_pri_i ? p_r : s_r;
    e.c = ctl_en_n_i ? 8'h00 : e_c;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic pulse(input int which, input logic [7:0] val, input bit hold_change);
    @(negedge clk);
    bus_i = val;
    case (which)
      0: wr_lo_i = 1; 1: wr_hi_i = 1; 2: wr_sw_i = 1; 3: hop_i = 1; default: wr_ctl_i = 1;
    endcase
    repeat (4) @(negedge clk);
    if (hold_change) begin
      bus_i = ~val;
      repeat (4) @(negedge clk);
    end
    {wr_lo_i, wr_hi_i, wr_sw_i, hop_i, wr_ctl_i} = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      wait (sb_q.size() > 0);
      @(negedge clk);
      begin
        exp_t e;
        e = sb_q[0];
        checks++;
        if (m_div_o !== e.m || a_div_o !== e.a || r_div_o !== e.r || ctl_o !== e.c) begin
          errors++;
          $display("FAIL %s: got m=%h a=%h r=%h c=%h expected m=%h a=%h r=%h c=%h",
                   e.req, m_div_o, a_div_o, r_div_o, ctl_o, e.m, e.a, e.r, e.c);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    push_exp("R1 reset");
    rst_n = 1;
    repeat (2) @(negedge clk);

    pulse(0, 8'hA5, 0); p_m[7:0] = 8'hA5;
    push_exp("R2 low byte");
    pulse(1, 8'hEB, 0); p_m[8] = 1'b1; p_r = 6'h2B;
    push_exp("R3 high section bit7 dropped");
    pulse(2, 8'hF9, 0); p_a = 4'h9;
    push_exp("R4 swallow upper bits dropped");
    use_pri_i = 0;
    push_exp("R6 secondary still zero");
    pulse(3, 8'h00, 0); s_m = p_m; s_a = p_a; s_r = p_r;
    push_exp("R5 hop copy");
    pulse(0, 8'h3C, 0); p_m[7:0] = 8'h3C;
    pulse(1, 8'h05, 0); p_m[8] = 1'b0; p_r = 6'h05;
    push_exp("R5 secondary unchanged by primary load");
    use_pri_i = 1;
    push_exp("R6 live select primary");
    use_pri_i = 0;
    push_exp("R6 live select secondary");

    pulse(4, 8'h6E, 0); e_c = 8'h6E;
    push_exp("R7 control masked");
    ctl_en_n_i = 0;
    push_exp("R7 control enabled");

    mode_a_i = 1;
    pulse(0, 8'hFF, 0);
    pulse(4, 8'h11, 0);
    use_pri_i = 1;
    push_exp("R8 mode_a blocks writes");
    mode_a_i = 0; mode_b_i = 1;
    pulse(3, 8'h00, 0);
    use_pri_i = 0;
    push_exp("R8 mode_b blocks hop");
    mode_b_i = 0;

    use_pri_i = 1;
    pulse(2, 8'h07, 1); p_a = 4'h7;
    push_exp("R9 held strobe captures once");
    pulse(3, 8'h00, 0); s_m = p_m; s_a = p_a; s_r = p_r;
    use_pri_i = 0;
    push_exp("R5 second hop");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule